// File: doc/BRIEF.md
# Fixed-Point Requantizer with Selectable Rounding and Saturation

This block narrows an IN_W-bit fixed-point word, signed or unsigned, to an output section whose bit indices run from SEC_HI down to SEC_LO of the input. It first discards the SEC_LO low bits. How they are folded into the kept part depends on one of eight rounding modes chosen at run time. The rounded value keeps one extra carry bit. A second stage then fits that value into the SEC_HI-SEC_LO+1 output bits. If the section sits below the input's top, the excess high bits are saturated away. If the section reaches above the input's top, the value is sign- or zero-extended.

A symmetric option applies to signed data only. It removes the most negative output code, so the output range becomes balanced around zero. An overflow flag marks every word whose value was changed by saturation or by the symmetric clamp.

The datapath is combinational. A parameter can add one output register stage, in which case the output and its valid flag follow the input by one clock. The block has no state machine. Its only sequential element is this optional register stage. It has a synchronous, active-high reset.

Top module: `fxp_requant`

## Requirements
- R1: Mode code 0 gives floor(x). Mode code 1 rounds toward zero, giving sign(x)·floor(|x|). Here x is the input divided by 2^SEC_LO.
- R2: Mode code 2 gives ceil(x). Mode code 3 rounds away from zero, giving sign(x)·ceil(|x|).
- R3: The half modes are as follows. Code 4 gives floor(x+0.5). Code 5 gives ceil(x-0.5). Code 6 gives sign(x)·ceil(|x|-0.5). Code 7 gives sign(x)·floor(|x|+0.5). With SEC_LO=2, code 7 maps input 10 (2.5) to 3 and input -10 (-2.5) to -3.
- R4: For signed data whose rounded value exceeds the output range, the output is the largest code (0 followed by ones) when the value is non-negative. It is the smallest code (1 followed by zeros) when the value is negative.
- R5: For unsigned data whose rounded value exceeds the output range, the output is all ones.
- R6: When the signed flag and the symmetric flag are both set, the output never shows the most negative code. That code is replaced by its negated maximum (1 followed by zeros and a final 1).
- R7: When SEC_HI is above the input's top bit, the rounded value is sign-extended (signed) or zero-extended (unsigned) into the output, and overflow is never raised.
- R8: out_ovf is high exactly when saturation or the symmetric clamp altered the value. Otherwise the output, read with the data's signedness, equals the rounded value.
- R9: With REG_OUT=1, dout, out_ovf and out_vld reflect the inputs presented one clock earlier. out_vld copies in_vld.
- R10: A synchronous active-high reset clears out_vld.
- R11: For unsigned data the symmetric flag has no effect: outputs equal those with the flag cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input word is valid |
| din | input | IN_W | Input fixed-point word |
| mode | input | 3 | Rounding mode code (0..7, see R1-R3 for codes) |
| is_signed | input | 1 | 1: din is two's complement; 0: unsigned |
| sym_en | input | 1 | Enables the symmetric clamp for signed data |
| dout | output | SEC_HI-SEC_LO+1 | Requantized word |
| out_vld | output | 1 | Output word is valid |
| out_ovf | output | 1 | Saturation or symmetric clamp changed the value |

## Verification
The bench sweeps every 8-bit input under all eight modes, both signednesses and both symmetric settings. It uses two builds: a narrowing section that saturates, and a section that reaches above the input and extends. Exact-half inputs of either sign separate the four half modes. A swapped tie rule would move -2.5 to -2 instead of -3, or 2.5 to 2 instead of 3. Positive values that carry into the extra bit, such as the largest input under ceil, catch a design that drops the carry. Such a design would wrap to a negative or small code instead of saturating. Unsigned words with the top bit set catch a sign-extending unsigned path. The symmetric cases confirm that only the most negative code is moved and that unsigned data ignores the flag. The register build is checked for its one-clock lag of valid and for valid cleared by reset.

// File: rtl/rq_pkg.sv
package rq_pkg;

    typedef enum logic [2:0] {
        RM_FLOOR      = 3'd0,
        RM_TRUNC_ZERO = 3'd1,
        RM_CEIL       = 3'd2,
        RM_CEIL_AWAY  = 3'd3,
        RM_HALF_UP    = 3'd4,
        RM_HALF_DOWN  = 3'd5,
        RM_HALF_ZERO  = 3'd6,
        RM_HALF_AWAY  = 3'd7
    } round_mode_e;

endpackage

// File: rtl/rq_round.sv
module rq_round
    import rq_pkg::*;
#(
    parameter int IN_W = 8,
    parameter int LO   = 2,
    localparam int RW  = IN_W - LO + 1
) (
    input  logic [IN_W-1:0] din,
    input  logic            is_signed,
    input  round_mode_e     mode,
    output logic [RW-1:0]   dout
);
    logic          neg;
    logic [IN_W:0] xw;
    logic [RW-1:0] q;
    logic          any_frac;
    logic          half_bit;
    logic          above_half;
    logic          inc;

    assign neg = is_signed & din[IN_W-1];
    assign xw  = {neg, din};
    assign q   = xw[IN_W:LO];

    generate
        if (LO == 0) begin : g_nofrac
            assign any_frac   = 1'b0;
            assign half_bit   = 1'b0;
            assign above_half = 1'b0;
        end else if (LO == 1) begin : g_onefrac
            assign any_frac   = din[0];
            assign half_bit   = din[0];
            assign above_half = 1'b0;
        end else begin : g_frac
            assign any_frac   = |din[LO-1:0];
            assign half_bit   = din[LO-1];
            assign above_half = din[LO-1] & (|din[LO-2:0]);
        end
    endgenerate

    always_comb begin
        unique case (mode)
            RM_FLOOR:      inc = 1'b0;
            RM_TRUNC_ZERO: inc = neg & any_frac;
            RM_CEIL:       inc = any_frac;
            RM_CEIL_AWAY:  inc = ~neg & any_frac;
            RM_HALF_UP:    inc = half_bit;
            RM_HALF_DOWN:  inc = above_half;
            RM_HALF_ZERO:  inc = neg ? half_bit : above_half;
            RM_HALF_AWAY:  inc = neg ? above_half : half_bit;
            default:       inc = 1'b0;
        endcase
    end

    assign dout = q + RW'(inc);

endmodule

// File: rtl/rq_fit.sv
module rq_fit #(
    parameter int RW = 7,
    parameter int OW = 4
) (
    input  logic [RW-1:0] din,
    input  logic          is_signed,
    input  logic          sym_en,
    output logic [OW-1:0] dout,
    output logic          ovf
);
    localparam logic [OW-1:0] MIN_CODE = {1'b1, {(OW-1){1'b0}}};
    localparam logic [OW-1:0] SYM_CODE = MIN_CODE | OW'(1);

    logic [OW-1:0] fitted;
    logic          sat_hit;
    logic          sym_hit;

    generate
        if (OW >= RW) begin : g_extend
            logic fill;
            assign fill    = is_signed & din[RW-1];
            assign sat_hit = 1'b0;
            for (genvar b = 0; b < OW; b++) begin : g_bit
                if (b < RW) begin : g_keep
                    assign fitted[b] = din[b];
                end else begin : g_fill
                    assign fitted[b] = fill;
                end
            end
        end else begin : g_saturate
            localparam int KEEP = RW - OW;
            logic [KEEP:0]   top_s;
            logic [KEEP-1:0] top_u;
            logic            fits_s;
            logic            fits_u;
            assign top_s  = din[RW-1:OW-1];
            assign top_u  = din[RW-1:OW];
            assign fits_s = (top_s == '0) | (top_s == '1);
            assign fits_u = (top_u == '0);
            always_comb begin
                fitted  = din[OW-1:0];
                sat_hit = 1'b0;
                if (is_signed) begin
                    if (!fits_s) begin
                        sat_hit = 1'b1;
                        fitted  = din[RW-1] ? MIN_CODE : ~MIN_CODE;
                    end
                end else if (!fits_u) begin
                    sat_hit = 1'b1;
                    fitted  = '1;
                end
            end
        end
    endgenerate

    assign sym_hit = is_signed & sym_en & (fitted == MIN_CODE);
    assign dout    = sym_hit ? SYM_CODE : fitted;
    assign ovf     = sat_hit | sym_hit;

endmodule

// File: rtl/rq_stage.sv
module rq_stage #(
    parameter int OW      = 4,
    parameter bit REG_OUT = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_vld,
    input  logic [OW-1:0] d,
    input  logic          ovf,
    output logic [OW-1:0] q,
    output logic          q_vld,
    output logic          q_ovf
);
    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    q_vld <= 1'b0;
                end else begin
                    q_vld <= in_vld;
                end
                q     <= d;
                q_ovf <= ovf;
            end

            assert_valid_lag_R9: assert property (@(posedge clk) disable iff (rst)
                !$past(rst) |-> (q_vld == $past(in_vld)));

            assert_ovf_lag_R9: assert property (@(posedge clk) disable iff (rst)
                !$past(rst) |-> (q_ovf == $past(ovf)));

            assert_reset_clears_R10: assert property (@(posedge clk)
                $past(rst) |-> !q_vld);
        end else begin : g_comb
            assign q     = d;
            assign q_vld = in_vld;
            assign q_ovf = ovf;
        end
    endgenerate

endmodule

// File: rtl/fxp_requant.sv
module fxp_requant
    import rq_pkg::*;
#(
    parameter int IN_W    = 8,
    parameter int SEC_HI  = 5,
    parameter int SEC_LO  = 2,
    parameter bit REG_OUT = 1'b1,
    localparam int OW     = SEC_HI - SEC_LO + 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_vld,
    input  logic [IN_W-1:0] din,
    input  logic [2:0]      mode,
    input  logic            is_signed,
    input  logic            sym_en,
    output logic [OW-1:0]   dout,
    output logic            out_vld,
    output logic            out_ovf
);
    localparam int RW = IN_W - SEC_LO + 1;
    localparam int CW = ((RW > OW) ? RW : OW) + 1;
    localparam logic [OW-1:0] MIN_CODE = {1'b1, {(OW-1){1'b0}}};

    logic [RW-1:0] rnd;
    logic [OW-1:0] fit_d;
    logic          fit_ovf;

    rq_round #(.IN_W(IN_W), .LO(SEC_LO)) u_round (
        .din       (din),
        .is_signed (is_signed),
        .mode      (round_mode_e'(mode)),
        .dout      (rnd)
    );

    rq_fit #(.RW(RW), .OW(OW)) u_fit (
        .din       (rnd),
        .is_signed (is_signed),
        .sym_en    (sym_en),
        .dout      (fit_d),
        .ovf       (fit_ovf)
    );

    rq_stage #(.OW(OW), .REG_OUT(REG_OUT)) u_stage (
        .clk    (clk),
        .rst    (rst),
        .in_vld (in_vld),
        .d      (fit_d),
        .ovf    (fit_ovf),
        .q      (dout),
        .q_vld  (out_vld),
        .q_ovf  (out_ovf)
    );

    // Values of the rounder and the fitter, widened with the data's signedness
    logic [CW-1:0] rnd_cmp;
    logic [CW-1:0] fit_cmp;
    assign rnd_cmp = is_signed ? CW'($signed(rnd))   : CW'(rnd);
    assign fit_cmp = is_signed ? CW'($signed(fit_d)) : CW'(fit_d);

    assert_value_kept_R8: assert property (@(posedge clk) disable iff (rst)
        (in_vld && !fit_ovf) |-> (rnd_cmp == fit_cmp));

    assert_sym_no_min_R6: assert property (@(posedge clk) disable iff (rst)
        (in_vld && is_signed && sym_en) |-> (fit_d != MIN_CODE));

    assert_pos_sat_max_R4: assert property (@(posedge clk) disable iff (rst)
        (in_vld && is_signed && fit_ovf && !rnd[RW-1]) |-> (fit_d == ~MIN_CODE));

    assert_uns_sat_ones_R5: assert property (@(posedge clk) disable iff (rst)
        (in_vld && !is_signed && fit_ovf) |-> (fit_d == '1));

endmodule

// File: tb/fxp_requant_tb.sv
`timescale 1ns/1ps
module fxp_requant_tb;

    localparam int IN_W  = 8;
    localparam int A_HI  = 5;
    localparam int A_LO  = 2;
    localparam int A_OW  = A_HI - A_LO + 1;
    localparam int B_HI  = 9;
    localparam int B_LO  = 3;
    localparam int B_OW  = B_HI - B_LO + 1;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_vld = 1'b0;
    logic [IN_W-1:0] din = '0;
    logic [2:0]      mode = '0;
    logic            is_signed = 1'b0;
    logic            sym_en = 1'b0;
    logic [A_OW-1:0] a_dout;
    logic            a_vld, a_ovf;
    logic [B_OW-1:0] b_dout;
    logic            b_vld, b_ovf;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    fxp_requant #(.IN_W(IN_W), .SEC_HI(A_HI), .SEC_LO(A_LO), .REG_OUT(1'b1)) u_dut (
        .clk(clk), .rst(rst), .in_vld(in_vld), .din(din), .mode(mode),
        .is_signed(is_signed), .sym_en(sym_en),
        .dout(a_dout), .out_vld(a_vld), .out_ovf(a_ovf)
    );

    fxp_requant #(.IN_W(IN_W), .SEC_HI(B_HI), .SEC_LO(B_LO), .REG_OUT(1'b0)) u_ext (
        .clk(clk), .rst(rst), .in_vld(in_vld), .din(din), .mode(mode),
        .is_signed(is_signed), .sym_en(sym_en),
        .dout(b_dout), .out_vld(b_vld), .out_ovf(b_ovf)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Arithmetic reference: returns the output code; ovf reports a changed value
    function automatic int model(input int raw, input bit sgn, input bit sym,
                                 input int md, input int lo, input int ow,
                                 output bit ovf, output bit clamped);
        int v, d, fl, rem, r, mn, mx;
        bit neg;
        v   = (sgn && raw >= 128) ? raw - 256 : raw;
        neg = (v < 0);
        d   = 1 << lo;
        fl  = v >>> lo;
        rem = v - fl * d;
        case (md)
            0: r = fl;
            1: r = neg ? fl + (rem != 0) : fl;
            2: r = fl + (rem != 0);
            3: r = neg ? fl : fl + (rem != 0);
            4: r = fl + (2 * rem >= d && rem != 0);
            5: r = fl + (2 * rem > d);
            6: r = neg ? fl + (2 * rem >= d && rem != 0) : fl + (2 * rem > d);
            default: r = neg ? fl + (2 * rem > d) : fl + (2 * rem >= d && rem != 0);
        endcase
        if (sgn) begin
            mn = -(1 << (ow - 1));
            mx = (1 << (ow - 1)) - 1;
        end else begin
            mn = 0;
            mx = (1 << ow) - 1;
        end
        ovf = 1'b0;
        clamped = 1'b0;
        if (r > mx) begin r = mx; ovf = 1'b1; clamped = 1'b1; end
        if (r < mn) begin r = mn; ovf = 1'b1; clamped = 1'b1; end
        if (sgn && sym && r == mn) begin r = mn + 1; ovf = 1'b1; end
        return r & ((1 << ow) - 1);
    endfunction

    function automatic string pick_tag(input int md, input bit sgn, input bit sym, input bit clamped);
        if (!sgn && sym) return "R11";
        if (sgn && sym)  return "R6";
        if (clamped)     return sgn ? "R4" : "R5";
        if (md < 2)      return "R1";
        if (md < 4)      return "R2";
        return "R3";
    endfunction

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int ea, eb;
        bit oa, ob, ca, cb;
        repeat (3) @(posedge clk);
        #1;
        check(a_vld == 1'b0, "R10 valid after reset", a_vld, 0);

        // Valid pulse pattern, register lag
        @(negedge clk);
        rst = 1'b0;
        in_vld = 1'b1;
        @(posedge clk); #1;
        check(a_vld == 1'b1, "R9 valid follows after one clock", a_vld, 1);
        @(negedge clk);
        in_vld = 1'b0;
        #1;
        check(a_vld == 1'b1, "R9 valid held before edge", a_vld, 1);
        @(posedge clk); #1;
        check(a_vld == 1'b0, "R9 valid drops after one clock", a_vld, 0);

        // Tie examples for half-away-from-zero
        @(negedge clk);
        in_vld = 1'b1; is_signed = 1'b1; sym_en = 1'b0; mode = 3'd7; din = 8'd10;
        @(posedge clk); #1;
        check(a_dout == 4'd3, "R3 2.5 to 3", a_dout, 3);
        @(negedge clk);
        din = 8'hF6;
        @(posedge clk); #1;
        check(a_dout == 4'hD, "R3 -2.5 to -3", a_dout, 13);

        // Reset mid-stream clears valid
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk); #1;
        check(a_vld == 1'b0, "R10 reset while valid", a_vld, 0);
        @(negedge clk);
        rst = 1'b0;

        // Full sweep
        for (int s = 0; s < 2; s++) begin
            for (int y = 0; y < 2; y++) begin
                for (int m = 0; m < 8; m++) begin
                    for (int v = 0; v < 256; v++) begin
                        @(negedge clk);
                        din = IN_W'(v); mode = 3'(m);
                        is_signed = s[0]; sym_en = y[0]; in_vld = 1'b1;
                        ea = model(v, s[0], y[0], m, A_LO, A_OW, oa, ca);
                        eb = model(v, s[0], y[0], m, B_LO, B_OW, ob, cb);
                        #1;
                        check(b_dout == B_OW'(eb), "R7 extended value", b_dout, eb);
                        check(b_ovf == ob, "R7 no overflow on extension", b_ovf, ob);
                        @(posedge clk); #1;
                        check(a_dout == A_OW'(ea), pick_tag(m, s[0], y[0], ca), a_dout, ea);
                        check(a_ovf == oa, "R8 overflow flag", a_ovf, oa);
                    end
                end
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule